// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between a 64-bit integer datapath and a 64-bit-wide data memory port whose bytes are individually addressable. On the store side it takes the low bits of the effective address, an access size and a register value. It produces a byte-enable mask and a write word in which the value already sits in the right byte lanes. On the load side it takes the 64-bit word returned by memory, picks out the addressed byte, halfword, word or doubleword, and widens it to 64 bits. The widening is by sign or by zero, as requested.

Byte ordering inside the memory word is chosen at run time by one input, either little-endian or big-endian. An access that is not naturally aligned to its own size is not split. It is reported on a fault output, and all its effects are suppressed. The unit has no state and no clock: every output follows its inputs within the same cycle. Address generation, caching and the memory array are not part of this block.

Top module: `lsa_unit`

## Requirements
- R1: `misalign` is 1 exactly when any of the `acc_size` lowest bits of `addr_lo` is nonzero; a byte access is never misaligned.
- R2: The size code on `acc_size` is 0 for byte, 1 for halfword, 2 for word and 3 for doubleword, covering 1, 2, 4 and 8 bytes.
- R3: While `misalign` is 1, `byte_en` is all zero and `ld_data` is all zero.
- R4: For an aligned access, `byte_en` has exactly the lanes the access covers set, where bit k enables data bits 8k+7..8k. The lane for address offset o is o in little-endian mode (`big_endian`=0) and 7-o in big-endian mode.
- R5: `mem_wdata` holds the low 1, 2, 4 or 8 bytes of `st_data` repeated across the whole word, with byte 0 of the value in lane 0. It therefore does not depend on the address or the byte order.
- R6: In little-endian mode, an aligned load returns the field whose least significant byte is the lane at the access offset.
- R7: In big-endian mode, an aligned load returns the field whose most significant byte is the byte at the lowest covered address, in lane 7 minus that offset.
- R8: With `ld_signed`=0, every bit of `ld_data` above the selected field is 0.
- R9: With `ld_signed`=1, every bit of `ld_data` above the selected field equals the field's top bit.
- R10: A doubleword load at offset 0 returns `mem_rdata` unchanged in both byte orders.
- R11: Outputs change with the inputs without any clock edge, because the unit is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_lo | input | 3 | Low bits of the effective byte address |
| acc_size | input | 2 | Access size code |
| ld_signed | input | 1 | 1 selects sign extension of load data |
| big_endian | input | 1 | 1 selects big-endian lane mapping |
| st_data | input | 64 | Register value to store |
| mem_rdata | input | 64 | Word read from memory |
| byte_en | output | 8 | Per-lane write enables |
| mem_wdata | output | 64 | Lane-aligned write word |
| ld_data | output | 64 | Extended load result |
| misalign | output | 1 | Alignment fault flag |

## Verification
The bench builds the unit with its default 64-bit data width, which gives eight byte lanes, three offset bits and all four access sizes. It walks every size at every offset to cover the alignment rule. A fixed memory word with distinct, high-bit-mixed bytes shows which lane a load picked, and in which order the bytes were assembled, in both byte orders. The same word distinguishes sign from zero extension.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    LSA_SZ_BYTE  = 2'd0,
    LSA_SZ_HALF  = 2'd1,
    LSA_SZ_WORD  = 2'd2,
    LSA_SZ_DWORD = 2'd3
  } lsa_size_e;
endpackage

// File: rtl/lsa_lane_ctl.sv
module lsa_lane_ctl #(
  parameter int NB    = 8,
  parameter int OFS_W = $clog2(NB)
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [1:0]       size,
  input  logic             big,
  output logic [OFS_W:0]   nbytes,
  output logic [OFS_W-1:0] base_lane,
  output logic             mis
);
  logic [OFS_W:0] full;

  always_comb begin
    nbytes    = (OFS_W+1)'(1) << size;
    mis       = |(ofs & OFS_W'(nbytes - 1'b1));
    full      = (OFS_W+1)'(NB) - nbytes - {1'b0, ofs};
    base_lane = big ? full[OFS_W-1:0] : ofs;
  end
endmodule

// File: rtl/lsa_store_path.sv
module lsa_store_path #(
  parameter int DATA_W = 64,
  parameter int NB     = DATA_W / 8,
  parameter int OFS_W  = $clog2(NB)
) (
  input  logic [DATA_W-1:0] value,
  input  logic [OFS_W:0]    nbytes,
  input  logic [OFS_W-1:0]  base_lane,
  input  logic              mis,
  output logic [NB-1:0]     be,
  output logic [DATA_W-1:0] wdata
);
  logic [OFS_W-1:0] wrap;

  assign wrap = OFS_W'(nbytes - 1'b1);

  for (genvar k = 0; k < NB; k++) begin : g_lane
    logic [OFS_W-1:0] src;
    assign src = OFS_W'(k) & wrap;
    assign wdata[8*k +: 8] = value[{src, 3'b000} +: 8];
    assign be[k] = !mis && (k >= int'(base_lane))
                        && (k < int'(base_lane) + int'(nbytes));
  end
endmodule

// File: rtl/lsa_load_path.sv
module lsa_load_path #(
  parameter int DATA_W = 64,
  parameter int NB     = DATA_W / 8,
  parameter int OFS_W  = $clog2(NB),
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [OFS_W:0]    nbytes,
  input  logic [OFS_W-1:0]  base_lane,
  input  logic              sign_ext,
  input  logic              mis,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] shifted;
  logic              top;
  int                nbits;

  always_comb begin
    shifted = rdata >> {base_lane, 3'b000};
    nbits   = 8 * int'(nbytes);
    top     = shifted[IDX_W'(nbits - 1)];
    for (int i = 0; i < DATA_W; i++) begin
      result[i] = (i < nbits) ? shifted[i] : (sign_ext & top);
    end
    if (mis) result = '0;
  end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit #(
  parameter int DATA_W = 64,
  parameter int NB     = DATA_W / 8,
  parameter int OFS_W  = $clog2(NB)
) (
  input  logic [OFS_W-1:0]  addr_lo,
  input  logic [1:0]        acc_size,
  input  logic              ld_signed,
  input  logic              big_endian,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [NB-1:0]     byte_en,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] ld_data,
  output logic              misalign
);
  logic [OFS_W:0]   nbytes;
  logic [OFS_W-1:0] base_lane;
  logic             mis;

  lsa_lane_ctl #(.NB(NB), .OFS_W(OFS_W)) u_ctl (
    .ofs(addr_lo), .size(acc_size), .big(big_endian),
    .nbytes(nbytes), .base_lane(base_lane), .mis(mis)
  );

  lsa_store_path #(.DATA_W(DATA_W), .NB(NB), .OFS_W(OFS_W)) u_st (
    .value(st_data), .nbytes(nbytes), .base_lane(base_lane), .mis(mis),
    .be(byte_en), .wdata(mem_wdata)
  );

  lsa_load_path #(.DATA_W(DATA_W), .NB(NB), .OFS_W(OFS_W)) u_ld (
    .rdata(mem_rdata), .nbytes(nbytes), .base_lane(base_lane),
    .sign_ext(ld_signed), .mis(mis), .result(ld_data)
  );

  assign misalign = mis;
endmodule

// File: rtl/lsa_unit_chk.sv
module lsa_unit_chk #(
  parameter int DATA_W = 64,
  parameter int NB     = DATA_W / 8,
  parameter int OFS_W  = $clog2(NB)
) (
  input logic [OFS_W-1:0]  addr_lo,
  input logic [1:0]        acc_size,
  input logic              ld_signed,
  input logic [NB-1:0]     byte_en,
  input logic [DATA_W-1:0] ld_data,
  input logic              misalign
);
  always_comb begin
    // R1: a byte access never faults
    a_r1_byte_aligned: assert (!(acc_size == 2'd0 && misalign));
    // R1: odd address with wider access must fault
    a_r1_odd_faults: assert (!(acc_size != 2'd0 && addr_lo[0] && !misalign));
    // R3: fault suppresses lanes and load data
    a_r3_quiet_fault: assert (!misalign || (byte_en == '0 && ld_data == '0));
    // R4: aligned access enables exactly its byte count
    a_r4_lane_count: assert (misalign || $countones(byte_en) == (1 << acc_size));
    // R8: unsigned byte load has zero upper bits
    a_r8_zero_ext: assert (misalign || ld_signed || acc_size != 2'd0
                           || ld_data[DATA_W-1:8] == '0);
    // R9: signed halfword load copies bit 15 upward
    a_r9_sign_ext: assert (misalign || !ld_signed || acc_size != 2'd1
                           || ld_data[DATA_W-1:16] == {(DATA_W-16){ld_data[15]}});
  end
endmodule

bind lsa_unit lsa_unit_chk #(.DATA_W(DATA_W), .NB(NB), .OFS_W(OFS_W)) u_chk (
  .addr_lo(addr_lo), .acc_size(acc_size), .ld_signed(ld_signed),
  .byte_en(byte_en), .ld_data(ld_data), .misalign(misalign)
);

// File: tb/lsa_unit_test.sv
`timescale 1ns/1ps
module lsa_unit_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  addr_lo;
  logic [1:0]  acc_size;
  logic        ld_signed, big_endian;
  logic [63:0] st_data, mem_rdata;
  logic [7:0]  byte_en;
  logic [63:0] mem_wdata, ld_data;
  logic        misalign;

  lsa_unit uut (
    .addr_lo(addr_lo), .acc_size(acc_size), .ld_signed(ld_signed),
    .big_endian(big_endian), .st_data(st_data), .mem_rdata(mem_rdata),
    .byte_en(byte_en), .mem_wdata(mem_wdata), .ld_data(ld_data),
    .misalign(misalign)
  );

  localparam logic [63:0] RWORD = 64'hF1E2_D3C4_B5A6_9788;
  localparam logic [63:0] SVAL  = 64'h0123_4567_89AB_CDEF;

  typedef struct packed {
    logic [2:0]  ofs;
    logic [1:0]  sz;
    logic        sgn;
    logic        big;
    logic [7:0]  be;
    logic [63:0] wd;
    logic [63:0] ld;
    logic        mis;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 2'd0, 1'b0, 1'b0, 8'h08, 64'hEFEF_EFEF_EFEF_EFEF, 64'h0000_0000_0000_00B5, 1'b0},
    '{3'd3, 2'd0, 1'b1, 1'b0, 8'h08, 64'hEFEF_EFEF_EFEF_EFEF, 64'hFFFF_FFFF_FFFF_FFB5, 1'b0},
    '{3'd3, 2'd0, 1'b1, 1'b1, 8'h10, 64'hEFEF_EFEF_EFEF_EFEF, 64'hFFFF_FFFF_FFFF_FFC4, 1'b0},
    '{3'd2, 2'd1, 1'b0, 1'b0, 8'h0C, 64'hCDEF_CDEF_CDEF_CDEF, 64'h0000_0000_0000_B5A6, 1'b0},
    '{3'd2, 2'd1, 1'b1, 1'b1, 8'h30, 64'hCDEF_CDEF_CDEF_CDEF, 64'hFFFF_FFFF_FFFF_D3C4, 1'b0},
    '{3'd4, 2'd2, 1'b1, 1'b0, 8'hF0, 64'h89AB_CDEF_89AB_CDEF, 64'hFFFF_FFFF_F1E2_D3C4, 1'b0},
    '{3'd4, 2'd2, 1'b0, 1'b1, 8'h0F, 64'h89AB_CDEF_89AB_CDEF, 64'h0000_0000_B5A6_9788, 1'b0},
    '{3'd0, 2'd3, 1'b1, 1'b0, 8'hFF, SVAL,                    RWORD,                  1'b0},
    '{3'd0, 2'd3, 1'b0, 1'b1, 8'hFF, SVAL,                    RWORD,                  1'b0},
    '{3'd1, 2'd1, 1'b0, 1'b0, 8'h00, 64'hCDEF_CDEF_CDEF_CDEF, 64'h0,                  1'b1},
    '{3'd2, 2'd2, 1'b1, 1'b1, 8'h00, 64'h89AB_CDEF_89AB_CDEF, 64'h0,                  1'b1},
    '{3'd4, 2'd3, 1'b0, 1'b0, 8'h00, SVAL,                    64'h0,                  1'b1},
    '{3'd7, 2'd0, 1'b0, 1'b1, 8'h01, 64'hEFEF_EFEF_EFEF_EFEF, 64'h0000_0000_0000_0088, 1'b0},
    '{3'd6, 2'd1, 1'b1, 1'b0, 8'hC0, 64'hCDEF_CDEF_CDEF_CDEF, 64'hFFFF_FFFF_FFFF_F1E2, 1'b0}
  };

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [1:0] s, input logic sg,
                       input logic bg, input logic [63:0] sv, input logic [63:0] rd);
    @(negedge clk);
    addr_lo = o; acc_size = s; ld_signed = sg; big_endian = bg;
    st_data = sv; mem_rdata = rd;
    #1;
  endtask

  initial begin
    addr_lo = '0; acc_size = '0; ld_signed = 1'b0; big_endian = 1'b0;
    st_data = '0; mem_rdata = '0;
    repeat (2) @(posedge clk);

    // Table walk: R4 lanes, R5 write data, R6/R7 selection, R8/R9 extension, R3 faults
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].ofs, VECS[v].sz, VECS[v].sgn, VECS[v].big, SVAL, RWORD);
      check("R1 table misalign", {63'd0, misalign}, {63'd0, VECS[v].mis});
      check("R4 table byte_en", {56'd0, byte_en}, {56'd0, VECS[v].be});
      check("R5 table wdata", mem_wdata, VECS[v].wd);
      check("R6 table ld_data", ld_data, VECS[v].ld);
    end

    // R1 and R2: every size at every offset
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 8; o++) begin
        drive(3'(o), 2'(s), 1'b0, 1'b0, SVAL, RWORD);
        check("R1 sweep misalign", {63'd0, misalign},
              {63'd0, ((o & ((1 << s) - 1)) != 0)});
        if ((o & ((1 << s) - 1)) == 0)
          check("R2 sweep lane count", 64'($countones(byte_en)), 64'(1 << s));
        else
          check("R3 sweep quiet", {56'd0, byte_en}, 64'd0);
      end
    end

    // R7: big-endian byte at offset 0 is lane 7
    drive(3'd0, 2'd0, 1'b0, 1'b1, SVAL, RWORD);
    check("R7 big byte0", ld_data, 64'h0000_0000_0000_00F1);
    // R8: unsigned word, little-endian offset 0
    drive(3'd0, 2'd2, 1'b0, 1'b0, SVAL, RWORD);
    check("R8 zero ext word", ld_data, 64'h0000_0000_B5A6_9788);
    // R9: signed byte with top bit set
    drive(3'd0, 2'd0, 1'b1, 1'b0, SVAL, RWORD);
    check("R9 sign ext byte", ld_data, 64'hFFFF_FFFF_FFFF_FF88);
    // R9: signed byte with top bit clear stays positive
    drive(3'd0, 2'd0, 1'b1, 1'b0, SVAL, 64'h0000_0000_0000_0071);
    check("R9 positive byte", ld_data, 64'h0000_0000_0000_0071);
    // R10: doubleword unchanged in both orders
    drive(3'd0, 2'd3, 1'b1, 1'b1, SVAL, 64'h8000_0000_0000_0001);
    check("R10 dword big", ld_data, 64'h8000_0000_0000_0001);
    // R3: misaligned signed half returns zero despite set bits
    drive(3'd3, 2'd1, 1'b1, 1'b0, SVAL, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R3 fault load zero", ld_data, 64'd0);
    // R11: outputs follow an input change without a clock edge
    @(posedge clk);
    #0.5;
    mem_rdata = 64'h0000_0000_0000_00AB;
    addr_lo = 3'd0; acc_size = 2'd0; ld_signed = 1'b0; big_endian = 1'b0;
    #1;
    check("R11 combinational", ld_data, 64'h0000_0000_0000_00AB);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule